// File: doc/BRIEF.md
# AGC Gain Loop Update

This block is the loop filter of a digital automatic gain control. Each valid output sample brings an unsigned magnitude measurement. The block subtracts the measurement from a programmed threshold, which gives a signed gain error. It scales that error by a loop gain and adds the result to a signed gain accumulator. The accumulator then saturates between a programmable lower limit and a programmable upper limit.

The loop gain is a 4-bit fractional mantissa times a power of two set by a 4-bit exponent. Two mantissa/exponent pairs are held on static configuration inputs, and a select input picks one of them at run time. When sync loading is enabled, a synchronizing pulse loads the accumulator from a master gain value instead of updating it. The surrounding logic computes the magnitude, writes the registers and converts the accumulated gain into a multiplier.

The threshold and the magnitude share one unsigned format: 13 bits, 3 integer bits above 10 fraction bits. The accumulator's least significant bit is 2^-(10+ACC_FRAC), with ACC_FRAC = 8 by default.

Top module: `agc_loop_update`

## Requirements
- R1: While rst_n is low at a clock edge, gain_acc and gain_err both become zero.
- R2: On a clock edge with sample_valid high, gain_err takes the 14-bit two's-complement value threshold minus magnitude. The value is visible after that edge.
- R3: On a clock edge with sample_valid high and no sync load, the accumulator adds the step floor(err * M * 2^ACC_FRAC / 2^(19-E)). Here err is the R2 error of the same cycle, M is the selected mantissa (0..15) and E is the selected exponent (0..15). A negative error lowers the gain. M = 0 leaves the gain unchanged.
- R4: gain_sel high selects the pair (mant1, exp1). gain_sel low selects the pair (mant0, exp0).
- R5: On a clock edge with sample_valid low and no sync load, gain_acc and gain_err keep their values.
- R6: After an update, the accumulator holds the sum clamped to the range gain_min to gain_max, both signed, with gain_min <= gain_max assumed. It never wraps.
- R7: On a clock edge with sync_en and sync_in both high, gain_acc loads master_gain unclamped, whether sample_valid is high or low. This load takes priority over a same-cycle update.
- R8: With sync_en low, sync_in has no effect. The accumulator follows R3, R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| threshold | input | 13 | Programmed threshold, unsigned, 3.10 format |
| mant0 | input | 4 | Loop gain pair 0 mantissa (value/16) |
| exp0 | input | 4 | Loop gain pair 0 exponent |
| mant1 | input | 4 | Loop gain pair 1 mantissa (value/16) |
| exp1 | input | 4 | Loop gain pair 1 exponent |
| gain_sel | input | 1 | Loop gain pair select, 1 = pair 1 |
| sync_en | input | 1 | Enables the sync load |
| sync_in | input | 1 | Sync pulse that loads the master gain |
| master_gain | input | 24 | Value loaded on sync, signed |
| gain_max | input | 24 | Upper accumulator limit, signed |
| gain_min | input | 24 | Lower accumulator limit, signed |
| sample_valid | input | 1 | Marks a valid magnitude sample |
| magnitude | input | 13 | Magnitude measurement, unsigned, 3.10 format |
| gain_acc | output | 24 | Gain accumulator, signed |
| gain_err | output | 14 | Last gain error, signed |

## Verification
A sync load and a valid-sample update can fall on the same clock edge. Sync must win, while gain_err still records that cycle's error. The bench provokes this with directed cycles where sync_en, sync_in and sample_valid are all high. It also raises sync_in at random against random valid strobes. A reference model applies the sync-first priority, and each cycle's gain_acc and gain_err are compared against it.

// File: rtl/agc_pkg.sv
// Package: shared types and widths for the AGC gain loop.
// Assumes 4-bit mantissa and 4-bit exponent loop gain fields.
package agc_pkg;
    localparam int MANT_W = 4;
    localparam int EXP_W  = 4;
    // Total right shift applied to the product is MANT_W + (MAX_EXP - E).
    localparam int MAX_EXP = (1 << EXP_W) - 1;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [EXP_W-1:0]  expo;
    } gain_pair_t;
endpackage

// File: rtl/agc_err_calc.sv
// Module: gain error calculation.
// Computes threshold - magnitude combinationally for the accumulator path,
// and registers it as the visible error on each valid sample.
// Assumes threshold and magnitude share one unsigned fixed-point format.
module agc_err_calc #(
    parameter int THR_W = 13,
    localparam int ERR_W = THR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_valid,
    input  logic [THR_W-1:0]        threshold,
    input  logic [THR_W-1:0]        magnitude,
    output logic signed [ERR_W-1:0] err_now,
    output logic signed [ERR_W-1:0] err_q
);
    // Difference of the zero-extended operands.
    always_comb begin
        err_now = $signed({1'b0, threshold}) - $signed({1'b0, magnitude});
    end

    // Capture the error on valid samples only.
    always_ff @(posedge clk) begin
        if (!rst_n)            err_q <= '0;
        else if (sample_valid) err_q <= err_now;
    end

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> $stable(err_q)); // R5
endmodule

// File: rtl/agc_gain_scale.sv
// Module: loop gain scaling.
// Selects one of two mantissa/exponent pairs and forms the signed step
// err * M * 2^ACC_FRAC / 2^(MANT_W + MAX_EXP - E), rounded toward minus
// infinity by an arithmetic shift. Purely combinational.
module agc_gain_scale
    import agc_pkg::*;
#(
    parameter int ERR_W    = 14,
    parameter int ACC_FRAC = 8,
    localparam int PROD_W  = ERR_W + MANT_W + 1,
    localparam int STEP_W  = PROD_W + ACC_FRAC
) (
    input  logic signed [ERR_W-1:0]  err,
    input  gain_pair_t               pair0,
    input  gain_pair_t               pair1,
    input  logic                     gain_sel,
    output logic signed [STEP_W-1:0] step
);
    gain_pair_t                act;
    logic signed [PROD_W-1:0]  prod;
    logic signed [STEP_W-1:0]  widened;
    logic [EXP_W:0]            shamt;

    // Pick the active gain pair.
    always_comb begin
        act = gain_sel ? pair1 : pair0;
    end

    // Multiply by the mantissa, align to the accumulator, then shift down.
    always_comb begin
        prod    = err * $signed({1'b0, act.mant});
        widened = STEP_W'(prod) <<< ACC_FRAC;
        shamt   = (EXP_W+1)'(MANT_W) + (EXP_W+1)'(MAX_EXP) - {1'b0, act.expo};
        step    = widened >>> shamt;
    end

    // A zero mantissa must yield no change in gain.
    always_comb begin
        AST_ZERO_MANT_NO_STEP: assert (act.mant != '0 || step == '0); // R3
    end
endmodule

// File: rtl/agc_accum.sv
// Module: gain accumulator with saturation and sync load.
// Sync load (when enabled) has priority over the valid-sample update.
// Assumes lim_min <= lim_max; the sync load is not clamped.
module agc_accum #(
    parameter int ACC_W  = 24,
    parameter int STEP_W = 27,
    localparam int SUM_W = ((ACC_W > STEP_W) ? ACC_W : STEP_W) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic                     sync_en,
    input  logic                     sync_in,
    input  logic signed [ACC_W-1:0]  master_gain,
    input  logic signed [ACC_W-1:0]  lim_max,
    input  logic signed [ACC_W-1:0]  lim_min,
    input  logic signed [STEP_W-1:0] step,
    output logic signed [ACC_W-1:0]  acc_q
);
    logic                    sync_load;
    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] clamped;

    // Decide whether this cycle is a sync load.
    always_comb begin
        sync_load = sync_en && sync_in;
    end

    // Full-width sum, then saturate to the programmed limits.
    always_comb begin
        sum = SUM_W'(acc_q) + SUM_W'(step);
        if (sum > SUM_W'(lim_max))      clamped = lim_max;
        else if (sum < SUM_W'(lim_min)) clamped = lim_min;
        else                            clamped = ACC_W'(sum);
    end

    // Accumulator register: reset, then sync load, then update.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc_q <= '0;
        else if (sync_load)    acc_q <= master_gain;
        else if (sample_valid) acc_q <= clamped;
    end

    AST_ACC_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !sync_load) |=> (acc_q <= $past(lim_max) && acc_q >= $past(lim_min))); // R6
    AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sync_load |=> acc_q == $past(master_gain)); // R7
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !sync_load) |=> $stable(acc_q)); // R5
endmodule

// File: rtl/agc_loop_update.sv
// Module: AGC loop filter top.
// Error = threshold - magnitude; gain accumulator += scaled error on each
// valid sample, saturated to limits; optional sync load from master gain.
// Assumes static configuration inputs and lim_min <= lim_max.
module agc_loop_update
    import agc_pkg::*;
#(
    parameter int THR_W    = 13,
    parameter int ACC_W    = 24,
    parameter int ACC_FRAC = 8,
    localparam int ERR_W   = THR_W + 1,
    localparam int STEP_W  = ERR_W + MANT_W + 1 + ACC_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [THR_W-1:0]        threshold,
    input  logic [MANT_W-1:0]       mant0,
    input  logic [EXP_W-1:0]        exp0,
    input  logic [MANT_W-1:0]       mant1,
    input  logic [EXP_W-1:0]        exp1,
    input  logic                    gain_sel,
    input  logic                    sync_en,
    input  logic                    sync_in,
    input  logic [ACC_W-1:0]        master_gain,
    input  logic [ACC_W-1:0]        gain_max,
    input  logic [ACC_W-1:0]        gain_min,
    input  logic                    sample_valid,
    input  logic [THR_W-1:0]        magnitude,
    output logic [ACC_W-1:0]        gain_acc,
    output logic [ERR_W-1:0]        gain_err
);
    logic signed [ERR_W-1:0]  err_now;
    logic signed [ERR_W-1:0]  err_q;
    logic signed [STEP_W-1:0] step;
    logic signed [ACC_W-1:0]  acc_q;
    gain_pair_t               pair0;
    gain_pair_t               pair1;

    // Pack the configuration pairs.
    always_comb begin
        pair0 = '{mant: mant0, expo: exp0};
        pair1 = '{mant: mant1, expo: exp1};
    end

    agc_err_calc #(.THR_W(THR_W)) u_err (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .threshold(threshold), .magnitude(magnitude),
        .err_now(err_now), .err_q(err_q)
    );

    agc_gain_scale #(.ERR_W(ERR_W), .ACC_FRAC(ACC_FRAC)) u_scale (
        .err(err_now), .pair0(pair0), .pair1(pair1),
        .gain_sel(gain_sel), .step(step)
    );

    agc_accum #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .sync_en(sync_en), .sync_in(sync_in),
        .master_gain($signed(master_gain)),
        .lim_max($signed(gain_max)), .lim_min($signed(gain_min)),
        .step(step), .acc_q(acc_q)
    );

    // Drive the outputs.
    always_comb begin
        gain_acc = acc_q;
        gain_err = err_q;
    end
endmodule

// File: tb/agc_loop_update_bench.sv
module agc_loop_update_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] threshold, magnitude;
    logic [3:0]  mant0, exp0, mant1, exp1;
    logic        gain_sel, sync_en, sync_in, sample_valid;
    logic [23:0] master_gain, gain_max, gain_min;
    logic [23:0] gain_acc;
    logic [13:0] gain_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    longint m_acc;
    longint m_err;

    always #4 clk = ~clk;

    agc_loop_update u_agc_loop_update (
        .clk(clk), .rst_n(rst_n), .threshold(threshold),
        .mant0(mant0), .exp0(exp0), .mant1(mant1), .exp1(exp1),
        .gain_sel(gain_sel), .sync_en(sync_en), .sync_in(sync_in),
        .master_gain(master_gain), .gain_max(gain_max), .gain_min(gain_min),
        .sample_valid(sample_valid), .magnitude(magnitude),
        .gain_acc(gain_acc), .gain_err(gain_err)
    );

    function automatic longint sx24(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint calc_step(input longint e, input int m, input int x);
        longint v;
        v = e * m * 256;
        return v >>> (19 - x);
    endfunction

    // Model of one clock edge (not in reset).
    task automatic model_edge();
        longint e, s, sum;
        int m, x;
        e = longint'(threshold) - longint'(magnitude);
        m = gain_sel ? int'(mant1) : int'(mant0);
        x = gain_sel ? int'(exp1) : int'(exp0);
        s = calc_step(e, m, x);
        if (sync_en && sync_in) m_acc = sx24(master_gain);
        else if (sample_valid) begin
            sum = m_acc + s;
            if (sum > sx24(gain_max)) sum = sx24(gain_max);
            else if (sum < sx24(gain_min)) sum = sx24(gain_min);
            m_acc = sum;
        end
        if (sample_valid) m_err = e;
    endtask

    task automatic check(input string req);
        checks++;
        if (sx24(gain_acc) != m_acc) begin
            errors++;
            $display("FAIL %s gain_acc actual %0d expected %0d", req, sx24(gain_acc), m_acc);
        end
        checks++;
        if (longint'($signed(gain_err)) != m_err) begin
            errors++;
            $display("FAIL %s gain_err actual %0d expected %0d", req, $signed(gain_err), m_err);
        end
    endtask

    // Inputs already set at a negedge; run one edge and compare.
    task automatic cycle(input string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n = 0; threshold = 13'd2048; magnitude = 13'd1000;
        mant0 = 4'd8; exp0 = 4'd12; mant1 = 4'd15; exp1 = 4'd15;
        gain_sel = 0; sync_en = 0; sync_in = 0; sample_valid = 1;
        master_gain = 24'd5000; gain_max = 24'd1000000; gain_min = -24'sd1000000;
        m_acc = 0; m_err = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1;

        // R2/R3 pair 0: err=1048, step = 1048*8*256>>>7 = 16768
        cycle("R3");
        // R4 pair 1: M=15, E=15: step = 1048*15*256>>>4
        gain_sel = 1; cycle("R4");
        // negative error lowers gain
        magnitude = 13'd4000; cycle("R3");
        // zero mantissa: no change in acc, err still updated
        mant1 = 4'd0; magnitude = 13'd10; cycle("R3");
        mant1 = 4'd15;
        // no valid: hold
        sample_valid = 0; magnitude = 13'd8000; cycle("R5");
        cycle("R5");
        // sync load and valid in the same cycle: sync wins
        sample_valid = 1; sync_en = 1; sync_in = 1; master_gain = -24'sd777; cycle("R7");
        // sync without valid
        sample_valid = 0; master_gain = 24'd12345; cycle("R7");
        // sync_in ignored when disabled
        sync_en = 0; sample_valid = 1; magnitude = 13'd0; threshold = 13'h1FFF; cycle("R8");
        sync_in = 0;
        // saturation at top
        gain_max = 24'd20000; gain_min = -24'sd20000;
        repeat (4) cycle("R6");
        // saturation at bottom
        threshold = 13'd0; magnitude = 13'h1FFF;
        repeat (6) cycle("R6");

        // constrained random
        for (int i = 0; i < 2000; i++) begin
            threshold    = 13'($urandom);
            magnitude    = 13'($urandom);
            mant0 = 4'($urandom); exp0 = 4'($urandom);
            mant1 = 4'($urandom); exp1 = 4'($urandom);
            gain_sel     = 1'($urandom);
            sample_valid = ($urandom % 4) != 0;
            sync_en      = ($urandom % 3) == 0;
            sync_in      = ($urandom % 8) == 0;
            master_gain  = 24'($signed(($urandom % 200001)) - 100000);
            if ((i % 200) == 0) begin
                if ($urandom % 2) begin gain_max = 24'd50000;   gain_min = -24'sd50000; end
                else              begin gain_max = 24'd4000000; gain_min = -24'sd4000000; end
            end
            cycle((sync_en && sync_in) ? "R7" : (sample_valid ? "R6" : "R5"));
        end

        // reset during operation
        rst_n = 0;
        @(posedge clk); m_acc = 0; m_err = 0;
        @(negedge clk); check("R1");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule